// File: doc/BRIEF.md
# State-Enable CSR Access Guard

This block decides, in the same cycle as a CSR access request, whether a hart with hypervisor support may touch a CSR that is gated by a state-enable bit. It looks at the current privilege, the virtualization flag, the privilege level the CSR nominally belongs to and the index of the guarding bit. The answer is one of three verdicts: allow, illegal-instruction or virtual-instruction fault. Three enable registers are consulted in a cascade. The machine register is checked first, then the hypervisor register, then the supervisor register. The level whose bit is clear decides which trap is raised.

The block also owns the three enable registers and the supervisor and hypervisor environment-config registers that one of the enable bits guards. Each of these registers has its own write mask. The rest of the CSR file uses the external target to ask about any other gated CSR. It uses the internal targets to read and write the registers held here. Writes take effect at the next rising clock edge. Read data and the verdict are combinational.

Top module: `csr_stateen_guard`

## Requirements
- R1: With `feat_en` low, every request gets verdict 0 (allow). Verdict codes are 0 allow, 1 illegal-instruction and 2 virtual-instruction.
- R2: With `cur_priv` = 3 (machine), every request is allowed whatever the enable registers hold. Privilege codes are 0 user, 1 supervisor and 3 machine.
- R3: From user or supervisor privilege, a clear guarding bit in the machine enable register gives verdict 1. This applies even when virtualized and takes precedence over every lower check.
- R4: When virtualized, with the machine bit set and the guarding bit in the hypervisor enable register clear, the verdict is 2. This takes precedence over the supervisor check.
- R5: The supervisor enable register is consulted only for a user-level CSR accessed from user privilege with `has_s_ext` high. A clear bit then gives verdict 1, or verdict 2 when virtualized. In every other case it is ignored.
- R6: `req_tgt` selects the target: 0 external (level `ext_lvl`, bit `ext_bit`), 1 machine enable, 2 its upper alias, 3 hypervisor enable, 4 its upper alias, 5 supervisor enable, 6 supervisor env-config, 7 hypervisor env-config, 8 its upper alias. Targets 6 to 8 are checked at supervisor level against bit 62. Targets 1 to 5 are always allowed.
- R7: In the three enable registers only bit 63 and bit 62 are writable. Writes through an upper alias use `wdata[31:0]` shifted up by 32. Upper-alias reads return bits 63:32 in the low half of `rdata`.
- R8: The supervisor env-config register writes only bits 0, 4, 5, 6 and 7 (mask 0xF1). The hypervisor env-config register also writes bits 62 and 63 when `xlen64` is high. Its upper alias writes only bits 62 and 63. All other bits keep their value.
- R9: After reset all five registers read zero.
- R10: A denied write changes no register, and a denied request drives `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | State-enable feature present and enabled |
| has_s_ext | input | 1 | Supervisor mode implemented |
| xlen64 | input | 1 | Hart runs with 64-bit registers |
| cur_priv | input | 2 | Current privilege level |
| virt_mode | input | 1 | Hart is virtualized (VS or VU) |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | Request is a write |
| req_tgt | input | 4 | Target selector |
| ext_lvl | input | 2 | Nominal privilege of an external CSR |
| ext_bit | input | 6 | Guarding bit index of an external CSR |
| wdata | input | 64 | Write data |
| verdict | output | 2 | Access verdict |
| rdata | output | 64 | Read data, zero when denied |

## Verification
A wrong bit held in an enable register shows up as a wrong verdict on the very next request that uses that bit. For that reason each cascade case is preloaded through the write port and then probed from the matching privilege in the following cycle. A corrupted write mask or a write that leaks through a denial is visible at `rdata` on the first machine-mode read after the write, one clock later. Upper-alias reads expose the shifted halves, so an error in either shift direction is caught the same way.

// File: rtl/stateen_pkg.sv
package stateen_pkg;
    localparam int REG_W        = 64;
    localparam int HALF_W       = REG_W / 2;
    localparam int BIT_IDX_W    = $clog2(REG_W);
    localparam int TGT_W        = 4;
    localparam int STATEN_POS   = REG_W - 1;
    localparam int ENVCFG_EN_POS = REG_W - 2;

    typedef logic [REG_W-1:0] word_t;

    localparam word_t SE_WMASK    = (word_t'(1) << STATEN_POS) | (word_t'(1) << ENVCFG_EN_POS);
    localparam word_t ENV_LO_MASK = word_t'(8'hF1);
    localparam word_t ENV_HI_MASK = (word_t'(1) << (REG_W - 1)) | (word_t'(1) << (REG_W - 2));

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'd0,
        VERD_ILLEGAL = 2'd1,
        VERD_VIRTUAL = 2'd2
    } verdict_e;

    typedef enum logic [TGT_W-1:0] {
        TGT_EXT     = 4'd0,
        TGT_MEN     = 4'd1,
        TGT_MEN_HI  = 4'd2,
        TGT_HEN     = 4'd3,
        TGT_HEN_HI  = 4'd4,
        TGT_SEN     = 4'd5,
        TGT_SENV    = 4'd6,
        TGT_HENV    = 4'd7,
        TGT_HENV_HI = 4'd8
    } tgt_e;

    typedef struct packed {
        word_t men;
        word_t hen;
        word_t sen;
        word_t senv;
        word_t henv;
    } regs_t;

    function automatic word_t merge_masked(word_t old_v, word_t new_v, word_t mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction
endpackage

// File: rtl/stateen_verdict.sv
module stateen_verdict
    import stateen_pkg::*;
(
    input  logic                 feat_en,
    input  logic                 has_s_ext,
    input  logic [1:0]           cur_priv,
    input  logic                 virt_mode,
    input  logic [1:0]           csr_lvl,
    input  logic [BIT_IDX_W-1:0] guard_idx,
    input  word_t                men,
    input  word_t                hen,
    input  word_t                sen,
    output logic [1:0]           verdict
);
    logic m_ok;
    logic h_ok;
    logic s_ok;
    logic s_applies;

    always_comb begin
        m_ok      = men[guard_idx];
        h_ok      = hen[guard_idx];
        s_ok      = sen[guard_idx];
        s_applies = (csr_lvl == PRIV_U) && (cur_priv == PRIV_U) && has_s_ext;

        if (!feat_en) begin
            verdict = VERD_ALLOW;
        end else if (cur_priv == PRIV_M) begin
            verdict = VERD_ALLOW;
        end else if (!m_ok) begin
            verdict = VERD_ILLEGAL;
        end else if (virt_mode && !h_ok) begin
            verdict = VERD_VIRTUAL;
        end else if (s_applies && !s_ok) begin
            verdict = virt_mode ? VERD_VIRTUAL : VERD_ILLEGAL;
        end else begin
            verdict = VERD_ALLOW;
        end
    end
endmodule

// File: rtl/stateen_regfile.sv
module stateen_regfile
    import stateen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TGT_W-1:0] wr_tgt,
    input  word_t            wr_data,
    input  logic             xlen64,
    output regs_t            regs_q
);
    regs_t regs_d;
    word_t hi_val;
    word_t henv_mask;

    always_comb begin
        regs_d    = regs_q;
        hi_val    = {wr_data[HALF_W-1:0], {HALF_W{1'b0}}};
        henv_mask = xlen64 ? (ENV_LO_MASK | ENV_HI_MASK) : ENV_LO_MASK;
        if (wr_en) begin
            case (tgt_e'(wr_tgt))
                TGT_MEN:     regs_d.men  = merge_masked(regs_q.men,  wr_data, SE_WMASK);
                TGT_MEN_HI:  regs_d.men  = merge_masked(regs_q.men,  hi_val,  SE_WMASK);
                TGT_HEN:     regs_d.hen  = merge_masked(regs_q.hen,  wr_data, SE_WMASK);
                TGT_HEN_HI:  regs_d.hen  = merge_masked(regs_q.hen,  hi_val,  SE_WMASK);
                TGT_SEN:     regs_d.sen  = merge_masked(regs_q.sen,  wr_data, SE_WMASK);
                TGT_SENV:    regs_d.senv = merge_masked(regs_q.senv, wr_data, ENV_LO_MASK);
                TGT_HENV:    regs_d.henv = merge_masked(regs_q.henv, wr_data, henv_mask);
                TGT_HENV_HI: regs_d.henv = merge_masked(regs_q.henv, hi_val,  ENV_HI_MASK);
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/csr_stateen_guard.sv
module csr_stateen_guard
    import stateen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 feat_en,
    input  logic                 has_s_ext,
    input  logic                 xlen64,
    input  logic [1:0]           cur_priv,
    input  logic                 virt_mode,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [TGT_W-1:0]     req_tgt,
    input  logic [1:0]           ext_lvl,
    input  logic [BIT_IDX_W-1:0] ext_bit,
    input  logic [REG_W-1:0]     wdata,
    output logic [1:0]           verdict,
    output logic [REG_W-1:0]     rdata
);
    regs_t                regs_q;
    logic                 is_ext;
    logic                 is_env;
    logic [1:0]           chk_lvl;
    logic [BIT_IDX_W-1:0] chk_idx;
    logic [1:0]           raw_verdict;
    logic                 granted;
    logic                 wr_en;
    word_t                rd_mux;

    always_comb begin
        is_ext  = (tgt_e'(req_tgt) == TGT_EXT);
        is_env  = (tgt_e'(req_tgt) == TGT_SENV) || (tgt_e'(req_tgt) == TGT_HENV)
               || (tgt_e'(req_tgt) == TGT_HENV_HI);
        chk_lvl = is_ext ? ext_lvl : PRIV_S;
        chk_idx = is_ext ? ext_bit : BIT_IDX_W'(ENVCFG_EN_POS);
    end

    stateen_verdict u_verdict (
        .feat_en   (feat_en),
        .has_s_ext (has_s_ext),
        .cur_priv  (cur_priv),
        .virt_mode (virt_mode),
        .csr_lvl   (chk_lvl),
        .guard_idx (chk_idx),
        .men       (regs_q.men),
        .hen       (regs_q.hen),
        .sen       (regs_q.sen),
        .verdict   (raw_verdict)
    );

    always_comb begin
        verdict = (req_valid && (is_ext || is_env)) ? raw_verdict : VERD_ALLOW;
        granted = req_valid && (verdict == VERD_ALLOW);
        wr_en   = granted && req_write && !is_ext;
        case (tgt_e'(req_tgt))
            TGT_MEN:     rd_mux = regs_q.men;
            TGT_MEN_HI:  rd_mux = {{HALF_W{1'b0}}, regs_q.men[REG_W-1:HALF_W]};
            TGT_HEN:     rd_mux = regs_q.hen;
            TGT_HEN_HI:  rd_mux = {{HALF_W{1'b0}}, regs_q.hen[REG_W-1:HALF_W]};
            TGT_SEN:     rd_mux = regs_q.sen;
            TGT_SENV:    rd_mux = regs_q.senv;
            TGT_HENV:    rd_mux = regs_q.henv;
            TGT_HENV_HI: rd_mux = {{HALF_W{1'b0}}, regs_q.henv[REG_W-1:HALF_W]};
            default:     rd_mux = '0;
        endcase
        rdata = granted ? rd_mux : '0;
    end

    stateen_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tgt  (req_tgt),
        .wr_data (wdata),
        .xlen64  (xlen64),
        .regs_q  (regs_q)
    );
endmodule

// File: rtl/stateen_guard_chk.sv
module stateen_guard_chk
    import stateen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             feat_en,
    input logic [1:0]       cur_priv,
    input logic             virt_mode,
    input logic             req_valid,
    input logic             req_write,
    input logic [TGT_W-1:0] req_tgt,
    input logic [1:0]       verdict,
    input logic [REG_W-1:0] rdata,
    input regs_t            regs
);
    logic env_tgt;
    assign env_tgt = (req_tgt >= 4'd6) && (req_tgt <= 4'd8);

    assert_feature_off_allow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !feat_en) |-> (verdict == 2'd0));

    assert_machine_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_en && cur_priv == 2'd3) |-> (verdict == 2'd0));

    assert_machine_deny_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_en && cur_priv != 2'd3 && env_tgt && !regs.men[ENVCFG_EN_POS])
        |-> (verdict == 2'd1));

    assert_hyp_deny_virtual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_en && cur_priv != 2'd3 && env_tgt && regs.men[ENVCFG_EN_POS]
         && virt_mode && !regs.hen[ENVCFG_EN_POS]) |-> (verdict == 2'd2));

    assert_enable_bits_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs.men & ~SE_WMASK) == '0) && ((regs.hen & ~SE_WMASK) == '0)
        && ((regs.sen & ~SE_WMASK) == '0));

    assert_senv_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.senv & ~ENV_LO_MASK) == '0);

    assert_denied_write_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && verdict != 2'd0) |=> $stable(regs));

    assert_denied_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && verdict != 2'd0) |-> (rdata == '0));
endmodule

bind csr_stateen_guard stateen_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .feat_en   (feat_en),
    .cur_priv  (cur_priv),
    .virt_mode (virt_mode),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_tgt   (req_tgt),
    .verdict   (verdict),
    .rdata     (rdata),
    .regs      (regs_q)
);

// File: tb/csr_stateen_guard_tb.sv
module csr_stateen_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b1;
    logic        has_s_ext = 1'b1;
    logic        xlen64 = 1'b1;
    logic [1:0]  cur_priv = 2'd3;
    logic        virt_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_tgt = 4'd0;
    logic [1:0]  ext_lvl = 2'd0;
    logic [5:0]  ext_bit = 6'd62;
    logic [63:0] wdata = '0;
    logic [1:0]  verdict;
    logic [63:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [63:0] B62 = 64'h4000_0000_0000_0000;
    localparam logic [63:0] ONES = '1;

    always #10 clk = ~clk;

    csr_stateen_guard u_dut (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .has_s_ext(has_s_ext),
        .xlen64(xlen64), .cur_priv(cur_priv), .virt_mode(virt_mode),
        .req_valid(req_valid), .req_write(req_write), .req_tgt(req_tgt),
        .ext_lvl(ext_lvl), .ext_bit(ext_bit), .wdata(wdata),
        .verdict(verdict), .rdata(rdata)
    );

    // {req, m, h, s, feat, has_s, priv, virt, csr_lvl, expected}
    localparam logic [15:0] VEC [0:12] = '{
        {4'd1, 3'b000, 2'b01, 2'd0, 1'b0, 2'd0, 2'd0}, // R1 feature off
        {4'd2, 3'b000, 2'b11, 2'd3, 1'b0, 2'd1, 2'd0}, // R2 machine bypass
        {4'd3, 3'b011, 2'b11, 2'd1, 1'b0, 2'd1, 2'd1}, // R3 supervisor denied
        {4'd3, 3'b011, 2'b11, 2'd0, 1'b1, 2'd0, 2'd1}, // R3 wins even in VU
        {4'd4, 3'b101, 2'b11, 2'd1, 1'b1, 2'd1, 2'd2}, // R4 VS denied by hyp
        {4'd4, 3'b100, 2'b11, 2'd0, 1'b1, 2'd0, 2'd2}, // R4 wins over supervisor
        {4'd5, 3'b110, 2'b11, 2'd0, 1'b0, 2'd0, 2'd1}, // R5 U denied
        {4'd5, 3'b110, 2'b11, 2'd0, 1'b1, 2'd0, 2'd2}, // R5 VU denied
        {4'd5, 3'b110, 2'b10, 2'd0, 1'b0, 2'd0, 2'd0}, // R5 no S mode
        {4'd5, 3'b110, 2'b11, 2'd0, 1'b0, 2'd1, 2'd0}, // R5 supervisor-level CSR
        {4'd5, 3'b110, 2'b11, 2'd1, 1'b0, 2'd0, 2'd0}, // R5 supervisor privilege
        {4'd5, 3'b111, 2'b11, 2'd0, 1'b1, 2'd0, 2'd0}, // R5 all set
        {4'd5, 3'b110, 2'b11, 2'd1, 1'b1, 2'd1, 2'd0}  // R5 VS ignores supervisor reg
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_m(input logic [3:0] t, input logic [63:0] d);
        @(negedge clk);
        feat_en = 1'b1; cur_priv = 2'd3; virt_mode = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_tgt = t; wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_m(input logic [3:0] t, output logic [63:0] v);
        @(negedge clk);
        feat_en = 1'b1; cur_priv = 2'd3; virt_mode = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_tgt = t;
        #1 v = rdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic probe(input logic [3:0] t, input logic [1:0] p, input logic vm,
                         input logic wr, input logic [63:0] d);
        @(negedge clk);
        cur_priv = p; virt_mode = vm; req_valid = 1'b1; req_write = wr;
        req_tgt = t; wdata = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd_m(4'd1, v); chk("R9 machine enable", v, 64'h0);
        rd_m(4'd3, v); chk("R9 hyp enable", v, 64'h0);
        rd_m(4'd5, v); chk("R9 sup enable", v, 64'h0);
        rd_m(4'd6, v); chk("R9 sup envcfg", v, 64'h0);
        rd_m(4'd7, v); chk("R9 hyp envcfg", v, 64'h0);

        // cascade table on external target, bit 62
        for (int i = 0; i < 13; i++) begin
            logic [15:0] e;
            e = VEC[i];
            wr_m(4'd1, e[11] ? B62 : 64'h0);
            wr_m(4'd3, e[10] ? B62 : 64'h0);
            wr_m(4'd5, e[9]  ? B62 : 64'h0);
            @(negedge clk);
            feat_en = e[8]; has_s_ext = e[7]; cur_priv = e[6:5]; virt_mode = e[4];
            ext_lvl = e[3:2]; ext_bit = 6'd62;
            req_valid = 1'b1; req_write = 1'b0; req_tgt = 4'd0;
            #1 chk($sformatf("R%0d vector %0d", e[15:12], i), 64'(verdict), 64'(e[1:0]));
            idle();
            has_s_ext = 1'b1;
        end

        // R7 enable register masks and upper alias
        wr_m(4'd1, ONES); rd_m(4'd1, v); chk("R7 machine mask", v, 64'hC000_0000_0000_0000);
        wr_m(4'd1, 64'h0); wr_m(4'd2, 64'h0000_0000_FFFF_FFFF);
        rd_m(4'd1, v); chk("R7 upper alias write", v, 64'hC000_0000_0000_0000);
        rd_m(4'd2, v); chk("R7 upper alias read", v, 64'h0000_0000_C000_0000);
        wr_m(4'd3, ONES); rd_m(4'd3, v); chk("R7 hyp mask", v, 64'hC000_0000_0000_0000);
        wr_m(4'd3, 64'h0); wr_m(4'd4, 64'hFFFF_FFFF_4000_0000);
        rd_m(4'd3, v); chk("R7 hyp upper alias", v, 64'h4000_0000_0000_0000);
        wr_m(4'd5, ONES); rd_m(4'd5, v); chk("R7 sup mask", v, 64'hC000_0000_0000_0000);

        // R8 env-config masks
        wr_m(4'd6, ONES); rd_m(4'd6, v); chk("R8 sup envcfg mask", v, 64'h0000_0000_0000_00F1);
        wr_m(4'd7, ONES); rd_m(4'd7, v); chk("R8 hyp envcfg xlen64", v, 64'hC000_0000_0000_00F1);
        wr_m(4'd7, 64'h0); xlen64 = 1'b0;
        wr_m(4'd7, ONES); rd_m(4'd7, v); chk("R8 hyp envcfg xlen32", v, 64'h0000_0000_0000_00F1);
        xlen64 = 1'b1;
        wr_m(4'd7, 64'h0); wr_m(4'd8, 64'h0000_0000_FFFF_FFFF);
        rd_m(4'd7, v); chk("R8 hyp envcfg upper write", v, 64'hC000_0000_0000_0000);
        rd_m(4'd8, v); chk("R8 hyp envcfg upper read", v, 64'h0000_0000_C000_0000);

        // R6 and R10 env-config guarding
        wr_m(4'd1, 64'h0);
        probe(4'd6, 2'd1, 1'b0, 1'b1, 64'h0);
        chk("R6 senvcfg guarded by machine bit", 64'(verdict), 64'd1);
        chk("R10 denied read data zero", rdata, 64'h0);
        idle();
        rd_m(4'd6, v); chk("R10 denied write no change", v, 64'h0000_0000_0000_00F1);
        probe(4'd8, 2'd0, 1'b0, 1'b0, 64'h0);
        chk("R6 henvcfg upper guarded", 64'(verdict), 64'd1);
        idle();
        probe(4'd1, 2'd1, 1'b0, 1'b0, 64'h0);
        chk("R6 enable register unchecked", 64'(verdict), 64'd0);
        idle();
        wr_m(4'd1, B62); wr_m(4'd3, 64'h0);
        probe(4'd7, 2'd1, 1'b1, 1'b0, 64'h0);
        chk("R6 henvcfg from VS hyp clear", 64'(verdict), 64'd2);
        idle();
        wr_m(4'd3, B62); wr_m(4'd5, 64'h0);
        probe(4'd6, 2'd0, 1'b0, 1'b0, 64'h0);
        chk("R6 supervisor level ignores sup reg", 64'(verdict), 64'd0);
        chk("R6 granted read data", rdata, 64'h0000_0000_0000_00F1);
        idle();

        // R5 with a different guard bit
        wr_m(4'd1, ONES); wr_m(4'd3, ONES); wr_m(4'd5, B62);
        @(negedge clk);
        cur_priv = 2'd0; virt_mode = 1'b0; ext_lvl = 2'd0; ext_bit = 6'd63;
        req_valid = 1'b1; req_write = 1'b0; req_tgt = 4'd0;
        #1 chk("R5 guard bit 63", 64'(verdict), 64'd1);
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule